// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block is the per-channel engine of an audio DMA controller. It walks a ring of 32 buffer descriptors held in system memory. Each time it moves to a new slot it issues one 8-byte read and decodes the returned descriptor into a buffer address, a length in 16-bit sample units, and two policy flags. An external stream port then reports how many units it has moved. The sequencer counts the remaining units down and steps the buffer address forward. When a buffer runs out, it either advances to the next slot or halts at the last valid slot that software has written.

Software controls the channel with a base address, a last-valid index and a run level. The sequencer reports the current and prefetch indices, the remaining count, a halted flag and a "current slot is the last valid slot" flag. It also emits one-cycle pulses for buffer completion and for last-buffer completion. While the channel is halted and still running, it tells the playback side to emit silence. The silence is either a repeat of the final sample frame or zeros, depending on a flag in the final descriptor.

Top module: `bdl_ring_seq`

## Requirements
- R1: After reset the channel is halted, the current index, prefetch index, last-valid index and remaining count are zero, no memory request is pending, and the last-slot flag, both event pulses and the silence indication are low.
- R2: The base address is stored with bits 1:0 cleared. The descriptor for slot i is requested at base + 8*i. In the 64-bit response, bits 31:0 are the buffer address, and that address is used with its bits 1:0 forced to zero.
- R3: Only one descriptor read is outstanding at a time. The request stays valid with a stable address until it is accepted. The remaining count loads from response bits 47:32, and no unit is consumed until the response has arrived.
- R4: An advance copies the prefetch index into the current index, then increments the prefetch index modulo 32, then fetches the descriptor of the new current slot.
- R5: A report of n units removes min(n, remaining) from the count and moves the buffer address forward by twice the units taken. Reports are ignored while the channel is halted or a fetch is in flight.
- R6: When a buffer that is not the last valid slot empties, the last-slot flag clears and the sequencer advances. The completion pulse fires exactly when response bit 63 of that descriptor was set.
- R7: When the last valid slot's buffer empties, the sequencer halts without fetching. The last-buffer pulse fires, the last-slot flag sets, and the completion pulse follows bit 63.
- R8: A freshly fetched descriptor of length zero raises no event. It advances if the current slot is not the last valid slot, and halts otherwise.
- R9: A last-valid index write stores the value modulo 32. If it arrives while the channel is halted and run is high, it clears the last-slot flag and triggers an advance. Otherwise it only stores the value.
- R10: A rising run level in the halted state triggers an advance. A low run level halts the channel; if a fetch is in flight, the halt waits for its response. The remaining count is kept.
- R11: Silence is requested while the channel is halted with run high. The fill mode is repeat-last-frame when the buffer that caused the last halt had response bit 62 set. It is zeros after any other last-buffer halt and after a zero-length halt.
- R12: If a last-valid write and the final consumption of the last valid buffer fall in the same cycle, the completion is judged against the previous last-valid index. The channel halts, and the new index is stored without restarting the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Base address write strobe |
| base_wdata | input | AW | Base address write data |
| lvi_wr | input | 1 | Last-valid index write strobe |
| lvi_wdata | input | 8 | Last-valid index write data |
| run | input | 1 | Channel run level |
| req_valid | output | 1 | Descriptor read request valid |
| req_ready | input | 1 | Descriptor read request accepted |
| req_addr | output | AW | Descriptor read address |
| rsp_valid | input | 1 | Descriptor read response valid |
| rsp_data | input | 64 | Descriptor read response data |
| xfer_valid | input | 1 | Stream port transfer report |
| xfer_units | input | 16 | Units moved in this report |
| buf_addr | output | 32 | Current buffer byte address |
| remain | output | 16 | Units left in current buffer |
| civ | output | IDX_W | Current slot index |
| piv | output | IDX_W | Prefetch slot index |
| lvi | output | IDX_W | Stored last-valid index |
| halted | output | 1 | Channel halted |
| celv | output | 1 | Current slot was the last valid slot at halt |
| evt_ioc | output | 1 | Buffer completion pulse |
| evt_lvb | output | 1 | Last-buffer completion pulse |
| fill_active | output | 1 | Emit silence |
| fill_last | output | 1 | Silence repeats last frame (else zeros) |

## Verification
Two functions can land in the same cycle: the final unit report of the last valid buffer, and a software write of a new last-valid index. The bench drives both strobes on the same clock edge while the current slot equals the old index. It then expects a last-buffer pulse, a halted channel and the new index stored with no restart, as R12 states. A second write of the same index must then restart the channel at the next slot. The ring wrap is checked with a full sweep of consecutive buffers.

// File: rtl/bdl_seq_pkg.sv
package bdl_seq_pkg;

  localparam int DESC_W   = 64;
  localparam int LEN_W    = 16;
  localparam int BUF_AW   = 32;
  localparam int LVI_IN_W = 8;
  localparam int LEN_LSB  = 32;
  localparam int IOC_BIT  = 63;
  localparam int KEEP_BIT = 62;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } bdl_state_e;

  typedef struct packed {
    logic              ioc;
    logic              keep_last;
    logic [LEN_W-1:0]  len;
    logic [BUF_AW-1:0] buf_addr;
  } desc_t;

endpackage

// File: rtl/bdl_rst_sync.sv
module bdl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bdl_idx_ring.sv
module bdl_idx_ring #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] civ,
  output logic [IDX_W-1:0] piv
);
  logic [IDX_W-1:0] civ_q, civ_d, piv_q, piv_d;

  always_comb begin
    civ_d = civ_q;
    piv_d = piv_q;
    if (adv) begin
      civ_d = piv_q;
      piv_d = piv_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      civ_q <= '0;
      piv_q <= '0;
    end else if (adv) begin
      civ_q <= civ_d;
      piv_q <= piv_d;
    end
  end

  assign civ = civ_q;
  assign piv = piv_q;
endmodule

// File: rtl/bdl_desc_fetch.sv
module bdl_desc_fetch
  import bdl_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic [IDX_W-1:0]  idx,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  input  logic [DESC_W-1:0] rsp_data,
  output logic              rsp_take,
  output desc_t             desc
);
  localparam int SLOT_SHIFT = 3;

  logic          pend_q, pend_d, wait_q, wait_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          unused_bits;

  always_comb begin
    pend_d   = pend_q;
    wait_d   = wait_q;
    addr_d   = addr_q;
    rsp_take = wait_q && rsp_valid;
    if (start && !pend_q && !wait_q) begin
      pend_d = 1'b1;
      addr_d = base + (AW'(idx) << SLOT_SHIFT);
    end
    if (pend_q && req_ready) begin
      pend_d = 1'b0;
      wait_d = 1'b1;
    end
    if (rsp_take) wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
      if (start) addr_q <= addr_d;
    end
  end

  assign req_valid      = pend_q;
  assign req_addr       = addr_q;
  assign desc.ioc       = rsp_data[IOC_BIT];
  assign desc.keep_last = rsp_data[KEEP_BIT];
  assign desc.len       = rsp_data[LEN_LSB +: LEN_W];
  assign desc.buf_addr  = {rsp_data[BUF_AW-1:2], 2'b00};
  assign unused_bits    = ^{rsp_data[KEEP_BIT-1:LEN_LSB+LEN_W], rsp_data[1:0]};
endmodule

// File: rtl/bdl_sample_cnt.sv
module bdl_sample_cnt
  import bdl_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [BUF_AW-1:0] load_addr,
  input  logic              take,
  input  logic [LEN_W-1:0]  units,
  output logic [LEN_W-1:0]  remain,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              empty,
  output logic              last_take
);
  localparam int PAD_W = BUF_AW - LEN_W - 1;

  logic [LEN_W-1:0]  rem_q, rem_d, step;
  logic [BUF_AW-1:0] addr_q, addr_d;

  always_comb begin
    last_take = (units >= rem_q);
    step      = last_take ? rem_q : units;
    rem_d     = rem_q;
    addr_d    = addr_q;
    if (load) begin
      rem_d  = load_len;
      addr_d = load_addr;
    end else if (take) begin
      rem_d  = rem_q - step;
      addr_d = addr_q + {{PAD_W{1'b0}}, step, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (load || take) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  assign remain   = rem_q;
  assign buf_addr = addr_q;
  assign empty    = (rem_q == '0);
endmodule

// File: rtl/bdl_ring_seq.sv
module bdl_ring_seq
  import bdl_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_wr,
  input  logic [AW-1:0]       base_wdata,
  input  logic                lvi_wr,
  input  logic [LVI_IN_W-1:0] lvi_wdata,
  input  logic                run,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  input  logic                rsp_valid,
  input  logic [DESC_W-1:0]   rsp_data,
  input  logic                xfer_valid,
  input  logic [LEN_W-1:0]    xfer_units,
  output logic [BUF_AW-1:0]   buf_addr,
  output logic [LEN_W-1:0]    remain,
  output logic [IDX_W-1:0]    civ,
  output logic [IDX_W-1:0]    piv,
  output logic [IDX_W-1:0]    lvi,
  output logic                halted,
  output logic                celv,
  output logic                evt_ioc,
  output logic                evt_lvb,
  output logic                fill_active,
  output logic                fill_last
);
  logic             rst_int_n;
  bdl_state_e       state_q, state_d;
  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] lvi_q;
  logic             run_q, run_rise;
  logic             celv_q, celv_d, ioc_q, ioc_d, lvb_q, lvb_d, keep_q, keep_d;
  logic             dioc_q, dkeep_q;
  logic             adv, take, rsp_take, cnt_empty, cnt_last, is_last;
  desc_t            desc;

  bdl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  bdl_idx_ring #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_int_n), .adv(adv), .civ(civ), .piv(piv)
  );

  bdl_desc_fetch #(.AW(AW), .IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .start(adv), .base(base_q), .idx(piv),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_take(rsp_take), .desc(desc)
  );

  bdl_sample_cnt u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(rsp_take), .load_len(desc.len),
    .load_addr(desc.buf_addr), .take(take), .units(xfer_units),
    .remain(remain), .buf_addr(buf_addr), .empty(cnt_empty), .last_take(cnt_last)
  );

  generate
    if (IDX_W < LVI_IN_W) begin : g_lvi_trim
      logic unused_lvi_hi;
      assign unused_lvi_hi = ^lvi_wdata[LVI_IN_W-1:IDX_W];
    end
  endgenerate

  logic unused_base_lo;
  assign unused_base_lo = ^base_wdata[1:0];

  assign run_rise = run && !run_q;
  assign is_last  = (civ == lvi_q);

  always_comb begin
    state_d = state_q;
    celv_d  = celv_q;
    keep_d  = keep_q;
    ioc_d   = 1'b0;
    lvb_d   = 1'b0;
    adv     = 1'b0;
    take    = 1'b0;
    case (state_q)
      ST_HALT: begin
        if (run_rise || (lvi_wr && run)) begin
          adv     = 1'b1;
          celv_d  = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rsp_take) state_d = run ? ST_RUN : ST_HALT;
      end
      ST_RUN: begin
        if (!run) begin
          state_d = ST_HALT;
        end else if (cnt_empty) begin
          if (is_last) begin
            keep_d  = 1'b0;
            state_d = ST_HALT;
          end else begin
            celv_d  = 1'b0;
            adv     = 1'b1;
            state_d = ST_FETCH;
          end
        end else if (xfer_valid) begin
          take = 1'b1;
          if (cnt_last) begin
            ioc_d = dioc_q;
            if (is_last) begin
              lvb_d   = 1'b1;
              celv_d  = 1'b1;
              keep_d  = dkeep_q;
              state_d = ST_HALT;
            end else begin
              celv_d  = 1'b0;
              adv     = 1'b1;
              state_d = ST_FETCH;
            end
          end
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_HALT;
      base_q  <= '0;
      lvi_q   <= '0;
      run_q   <= 1'b0;
      celv_q  <= 1'b0;
      ioc_q   <= 1'b0;
      lvb_q   <= 1'b0;
      keep_q  <= 1'b0;
      dioc_q  <= 1'b0;
      dkeep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run;
      celv_q  <= celv_d;
      ioc_q   <= ioc_d;
      lvb_q   <= lvb_d;
      keep_q  <= keep_d;
      if (base_wr) base_q <= {base_wdata[AW-1:2], 2'b00};
      if (lvi_wr)  lvi_q  <= lvi_wdata[IDX_W-1:0];
      if (rsp_take) begin
        dioc_q  <= desc.ioc;
        dkeep_q <= desc.keep_last;
      end
    end
  end

  assign lvi         = lvi_q;
  assign halted      = (state_q == ST_HALT);
  assign celv        = celv_q;
  assign evt_ioc     = ioc_q;
  assign evt_lvb     = lvb_q;
  assign fill_active = halted && run;
  assign fill_last   = keep_q;
endmodule

// File: rtl/bdl_ring_seq_chk.sv
module bdl_ring_seq_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic [IDX_W-1:0] civ,
  input logic [IDX_W-1:0] piv,
  input logic [15:0]      remain,
  input logic             halted,
  input logic             celv,
  input logic             evt_lvb
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R3

  AST_COUNT_FROZEN_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(remain)); // R3

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00)); // R2

  AST_CIV_FROM_PIV: assert property (@(posedge clk) disable iff (!rst_n)
    (civ != $past(civ)) |-> (civ == $past(piv))); // R4

  AST_PIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (piv != $past(piv)) |-> (piv == $past(piv) + 1'b1)); // R4

  AST_NO_REQ_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !req_valid); // R10

  AST_LVB_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lvb |-> (halted && celv)); // R7

  AST_HALT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(remain)); // R5
endmodule

bind bdl_ring_seq bdl_ring_seq_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .civ(civ), .piv(piv), .remain(remain),
  .halted(halted), .celv(celv), .evt_lvb(evt_lvb)
);

// File: tb/tb_bdl_ring_seq.sv
`timescale 1ns/1ps
module tb_bdl_ring_seq;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_wr, lvi_wr, run, req_ready, rsp_valid, xfer_valid;
  logic [31:0] base_wdata;
  logic [7:0]  lvi_wdata;
  logic [63:0] rsp_data;
  logic [15:0] xfer_units;
  logic        req_valid;
  logic [31:0] req_addr, buf_addr;
  logic [15:0] remain;
  logic [4:0]  civ, piv, lvi;
  logic        halted, celv, evt_ioc, evt_lvb, fill_active, fill_last;

  int ncmp = 0, nbad = 0, n_ioc = 0, n_lvb = 0, exp_ioc = 0, exp_lvb = 0;
  int len_tab[32];
  bit ioc_tab[32], keep_tab[32];
  logic [31:0] last_fetch = 32'hFFFF_FFFF;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  bdl_ring_seq dut (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .lvi_wr(lvi_wr), .lvi_wdata(lvi_wdata), .run(run), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .xfer_valid(xfer_valid), .xfer_units(xfer_units),
    .buf_addr(buf_addr), .remain(remain), .civ(civ), .piv(piv), .lvi(lvi),
    .halted(halted), .celv(celv), .evt_ioc(evt_ioc), .evt_lvb(evt_lvb),
    .fill_active(fill_active), .fill_last(fill_last)
  );

  function automatic logic [63:0] mkdesc(input int i);
    logic [31:0] w0, w1;
    w0 = 32'h4000_0000 + 32'(i) * 32'h100 + 32'h3;
    w1 = {ioc_tab[i], keep_tab[i], 14'h0, 16'(len_tab[i])};
    return {w1, w0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one idle cycle before accept, response one cycle later
  initial begin
    logic [31:0] cap;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_valid) begin
        @(negedge clk);
        cap = req_addr;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        last_fetch = cap;
        rsp_data = mkdesc(int'(((cap - BASE) >> 3) & 32'h1f));
        rsp_valid = 1'b1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_ioc += int'(evt_ioc);
    n_lvb += int'(evt_lvb);
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_lvi(input logic [7:0] v);
    @(negedge clk); lvi_wr = 1'b1; lvi_wdata = v;
    @(negedge clk); lvi_wr = 1'b0;
    settle(12);
  endtask

  task automatic consume(input logic [15:0] n);
    @(negedge clk); xfer_valid = 1'b1; xfer_units = n;
    @(negedge clk); xfer_valid = 1'b0;
    settle(22);
  endtask

  task automatic run_buf(input int i, input bit last);
    chk("R4 current index", 32'(civ), 32'(i));
    chk("R4 prefetch index", 32'(piv), 32'((i + 1) % 32));
    chk("R3 loaded length", 32'(remain), 32'(len_tab[i]));
    chk("R2 buffer address", buf_addr, 32'h4000_0000 + 32'(i) * 32'h100);
    chk("R2 descriptor address", last_fetch, BASE + 32'(i) * 8);
    consume(16'hFFFF);
    exp_ioc += int'(ioc_tab[i]);
    chk("R6 completion pulses", 32'(n_ioc), 32'(exp_ioc));
    if (last) begin
      exp_lvb++;
      chk("R7 halted", 32'(halted), 32'd1);
      chk("R7 last-slot flag", 32'(celv), 32'd1);
      chk("R7 last-buffer pulses", 32'(n_lvb), 32'(exp_lvb));
      chk("R11 fill mode", 32'(fill_last), 32'(keep_tab[i]));
      chk("R11 fill active", 32'(fill_active), 32'd1);
    end else begin
      chk("R6 last-slot flag clear", 32'(celv), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      nbad++; ncmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      len_tab[i]  = (i * 3) % 7 + 2;
      ioc_tab[i]  = (i % 2 == 0);
      keep_tab[i] = (i % 3 == 0);
    end
    len_tab[5] = 0;
    len_tab[8] = 0;
    rst_n = 1'b0; base_wr = 0; lvi_wr = 0; run = 0; xfer_valid = 0;
    base_wdata = '0; lvi_wdata = '0; xfer_units = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    // R1 reset state
    chk("R1 halted", 32'(halted), 32'd1);
    chk("R1 civ", 32'(civ), 0);
    chk("R1 piv", 32'(piv), 0);
    chk("R1 lvi", 32'(lvi), 0);
    chk("R1 remain", 32'(remain), 0);
    chk("R1 req idle", 32'(req_valid), 0);
    chk("R1 flags", {celv, evt_ioc, evt_lvb, fill_active, fill_last}, 0);

    @(negedge clk); base_wr = 1'b1; base_wdata = BASE | 32'h3;
    @(negedge clk); base_wr = 1'b0;
    write_lvi(8'd3);
    chk("R9 no restart while stopped", 32'(halted), 32'd1);
    @(negedge clk); run = 1'b1;
    settle(12);
    chk("R10 run start", 32'(halted), 32'd0);
    chk("R4 first advance", {27'd0, civ}, 0);
    chk("R2 base low bits cleared", last_fetch, BASE);
    chk("R3 len0", 32'(remain), 32'(len_tab[0]));
    consume(16'd1);
    chk("R5 partial remain", 32'(remain), 32'(len_tab[0] - 1));
    chk("R5 partial address", buf_addr, 32'h4000_0002);
    chk("R5 partial no event", 32'(n_ioc), 0);
    consume(16'hFFFF);
    exp_ioc += int'(ioc_tab[0]);
    chk("R6 pulse buf0", 32'(n_ioc), 32'(exp_ioc));
    for (int i = 1; i <= 3; i++) run_buf(i, i == 3);

    // ignored while halted
    consume(16'd5);
    chk("R5 halted remain", 32'(remain), 0);
    chk("R5 halted address", buf_addr, 32'h4000_0300 + 32'(len_tab[3]) * 2);

    // restart by last-valid write, modulo 32, zero-length in middle
    write_lvi(8'd38);
    chk("R9 stored mod 32", 32'(lvi), 32'd6);
    chk("R9 restart flag clear", 32'(celv), 0);
    run_buf(4, 0);
    chk("R8 zero-length silent", 32'(n_ioc), 32'(exp_ioc));
    run_buf(6, 1);

    // zero-length at last slot
    write_lvi(8'd8);
    run_buf(7, 0);
    chk("R8 zero-length halt", 32'(halted), 32'd1);
    chk("R8 zero-length civ", 32'(civ), 32'd8);
    chk("R8 no last-buffer pulse", 32'(n_lvb), 32'(exp_lvb));
    chk("R11 zero fill", 32'(fill_last), 0);

    // run low then wrap sweep
    @(negedge clk); run = 1'b0;
    settle(3);
    chk("R11 no fill when stopped", 32'(fill_active), 0);
    write_lvi(8'd1);
    chk("R9 stored while stopped", 32'(civ), 32'd8);
    @(negedge clk); run = 1'b1;
    settle(12);
    for (int k = 9; k <= 33; k++) run_buf(k % 32, k == 33);

    // run drop mid-buffer keeps count
    write_lvi(8'd3);
    chk("R9 restart index", 32'(civ), 32'd2);
    @(negedge clk); run = 1'b0;
    settle(4);
    chk("R10 run low halts", 32'(halted), 32'd1);
    chk("R10 count kept", 32'(remain), 32'(len_tab[2]));
    @(negedge clk); run = 1'b1;
    settle(12);
    chk("R10 rise advances", 32'(civ), 32'd3);
    chk("R10 running", 32'(halted), 0);

    // collision: final units and new last-valid index together
    @(negedge clk);
    xfer_valid = 1'b1; xfer_units = 16'hFFFF; lvi_wr = 1'b1; lvi_wdata = 8'd5;
    @(negedge clk);
    xfer_valid = 1'b0; lvi_wr = 1'b0;
    settle(12);
    exp_lvb++;
    chk("R12 halted on old index", 32'(halted), 32'd1);
    chk("R12 last-buffer pulse", 32'(n_lvb), 32'(exp_lvb));
    chk("R12 new index stored", 32'(lvi), 32'd5);
    chk("R12 no advance", 32'(civ), 32'd3);
    write_lvi(8'd5);
    chk("R12 later restart", 32'(civ), 32'd4);
    chk("R12 later running", 32'(halted), 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule